// File: doc/BRIEF.md
# Word-Serial Coefficient and Register Loader

This block is the load port through which a host fills the filter's coefficient banks and its small control registers over a 12-bit word bus. While the active-low load enable is held low, one word is taken on every clock. The first word of each transfer is an address: its top two bits pick the kind of target and the remaining bits give the index. A fixed number of data words for that kind then follow. The loader gathers them in a staging register and, once the last one is in, raises a single-cycle commit strobe that carries the kind, the index and the assembled wide value. The word after the last data word is again taken as an address.

Each target kind has its own word count and packing. A coefficient set is eight 12-bit words. A round value or a limit pair is four bytes, low byte first, each carried in bits 7:0 of its word. Select and configuration registers take a single 12-bit word. No target is written before every word for its address has arrived. If load enable goes high partway through a transfer, the partial data is thrown away. The storage banks are written from the commit strobe. A read port lets the datapath fetch any stored value by kind and index.

Top module: `wsl_loader`

## Requirements
- R1: A word is taken only at a clock edge where `load_n` is low. While `load_n` is high, activity on `word_in` changes no stored value and produces no commit.
- R2: Bits 11:10 of an address word give the kind: 00 is a coefficient set (index in bits 7:0, bits 9:8 must be 0), 01 is a select or configuration register, 10 is a round register, and 11 is a limit register (index in bits 3:0, bits 9:4 must be 0). An address with an out-of-range index writes nothing, and the next word is taken as a new address.
- R3: A coefficient set takes eight data words. The first word lands in value bits 11:0 and word k lands in bits 12k+11:12k. The commit kind code is 1.
- R4: A round register takes four data words. Bits 7:0 of each word form one byte, the first word giving the least significant byte of the 32-bit value. Bits 11:8 of these words are ignored. The commit kind code is 4.
- R5: A limit register takes four data words packed like R4. The lower limit is value bits 15:0 and the upper limit is bits 31:16. The commit kind code is 5.
- R6: A select or configuration register takes one 12-bit data word. Address bit 9 = 0 selects a select register (index in bits 3:0, kind code 2). Bit 9 = 1 selects a configuration register (index in bit 0, kind code 3). All other index bits must be 0.
- R7: `commit_valid` is high for exactly the one cycle after the edge that captures a transfer's last data word, with kind, index and value valid in that cycle. A new address may follow the last data word with no gap. `commit_valid` is 0 out of reset.
- R8: If `load_n` goes high before a transfer's last data word, the staged data is discarded with no commit, and the next low period starts with an address word.
- R9: A committed value can be read on `rd_value` (chosen by `rd_kind` and `rd_index`, zero-extended) from the cycle after the commit strobe. Select, configuration, round and limit registers read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low load enable |
| word_in | input | 12 | Load word bus |
| commit_valid | output | 1 | One-cycle commit strobe |
| commit_kind | output | 3 | Kind of the committed target (0 when idle) |
| commit_index | output | 10 | Index of the committed target |
| commit_value | output | 96 | Assembled value, zero-extended |
| rd_kind | input | 3 | Kind for the read port |
| rd_index | input | 10 | Index for the read port |
| rd_value | output | 96 | Stored value of the selected target |

## Verification
A transfer's last data word is driven on a falling edge and captured on the next rising edge. Its commit is therefore visible at the falling edge that follows, and the monitor samples `commit_valid` there against the head of the expected-item queue. Storage is written on the rising edge that ends the commit cycle. Read-back checks are made only after at least two further edges, with the read address applied and settled before sampling. Any commit that nothing was queued for, including one after idle activity, an abort or an invalid address, counts as a failure.

// File: rtl/wsl_pkg.sv
package wsl_pkg;

    typedef enum logic [2:0] {
        TK_NONE = 3'd0,
        TK_COEF = 3'd1,
        TK_SEL  = 3'd2,
        TK_CFG  = 3'd3,
        TK_RND  = 3'd4,
        TK_LIM  = 3'd5
    } tkind_e;

    localparam int BYTE_WORDS = 4;
    localparam int WIDE_W     = 32;

endpackage

// File: rtl/wsl_decode.sv
module wsl_decode
    import wsl_pkg::*;
#(
    parameter int WORD_W    = 12,
    parameter int COEF_TAPS = 8,
    parameter int COEF_SETS = 256,
    parameter int SEL_REGS  = 16,
    parameter int CFG_REGS  = 2,
    parameter int RND_REGS  = 16,
    parameter int LIM_REGS  = 16,
    localparam int IDX_W    = WORD_W - 2,
    localparam int CNT_W    = $clog2(COEF_TAPS + 1)
) (
    input  logic [WORD_W-1:0] addr_word,
    output tkind_e            dec_kind,
    output logic [IDX_W-1:0]  dec_index,
    output logic [CNT_W-1:0]  dec_words
);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-2:0] sub;

    assign idx = addr_word[IDX_W-1:0];
    assign sub = idx[IDX_W-2:0];

    // Decode table: kind field -> target kind, index range and word count
    always_comb begin
        dec_kind  = TK_NONE;
        dec_index = idx;
        dec_words = '0;
        case (addr_word[WORD_W-1 -: 2])
            2'b00: begin
                if (int'(idx) < COEF_SETS) begin
                    dec_kind  = TK_COEF;
                    dec_words = CNT_W'(COEF_TAPS);
                end
            end
            2'b01: begin
                dec_index = {1'b0, sub};
                if (idx[IDX_W-1]) begin
                    if (int'(sub) < CFG_REGS) begin
                        dec_kind  = TK_CFG;
                        dec_words = CNT_W'(1);
                    end
                end else if (int'(sub) < SEL_REGS) begin
                    dec_kind  = TK_SEL;
                    dec_words = CNT_W'(1);
                end
            end
            2'b10: begin
                if (int'(idx) < RND_REGS) begin
                    dec_kind  = TK_RND;
                    dec_words = CNT_W'(BYTE_WORDS);
                end
            end
            default: begin
                if (int'(idx) < LIM_REGS) begin
                    dec_kind  = TK_LIM;
                    dec_words = CNT_W'(BYTE_WORDS);
                end
            end
        endcase
    end

endmodule

// File: rtl/wsl_sequencer.sv
module wsl_sequencer
    import wsl_pkg::*;
#(
    parameter int WORD_W    = 12,
    parameter int COEF_TAPS = 8,
    localparam int IDX_W    = WORD_W - 2,
    localparam int CNT_W    = $clog2(COEF_TAPS + 1),
    localparam int VAL_W    = COEF_TAPS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [WORD_W-1:0] word_in,
    input  tkind_e            dec_kind,
    input  logic [IDX_W-1:0]  dec_index,
    input  logic [CNT_W-1:0]  dec_words,
    output logic              cm_valid,
    output tkind_e            cm_kind,
    output logic [IDX_W-1:0]  cm_index,
    output logic [VAL_W-1:0]  cm_value
);

    typedef struct packed {
        logic             busy;
        tkind_e           kind;
        logic [IDX_W-1:0] index;
        logic [CNT_W-1:0] left;
        logic [VAL_W-1:0] stage;
        logic             cvalid;
        tkind_e           ckind;
        logic [IDX_W-1:0] cidx;
        logic [VAL_W-1:0] cval;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d        = seq_q;
        seq_d.cvalid = 1'b0;
        seq_d.ckind  = TK_NONE;
        if (load_n) begin
            // idle or aborted: drop any partial transfer
            seq_d.busy  = 1'b0;
            seq_d.left  = '0;
            seq_d.stage = '0;
        end else if (!seq_q.busy) begin
            seq_d.stage = '0;
            if (dec_kind != TK_NONE) begin
                seq_d.busy  = 1'b1;
                seq_d.kind  = dec_kind;
                seq_d.index = dec_index;
                seq_d.left  = dec_words;
            end
        end else begin
            case (seq_q.kind)
                TK_COEF:
                    seq_d.stage = {word_in, seq_q.stage[VAL_W-1:WORD_W]};
                TK_RND, TK_LIM:
                    seq_d.stage = {{(VAL_W-WIDE_W){1'b0}}, word_in[7:0],
                                   seq_q.stage[WIDE_W-1:8]};
                default:
                    seq_d.stage = {{(VAL_W-WORD_W){1'b0}}, word_in};
            endcase
            seq_d.left = seq_q.left - CNT_W'(1);
            if (seq_q.left == CNT_W'(1)) begin
                seq_d.busy   = 1'b0;
                seq_d.cvalid = 1'b1;
                seq_d.ckind  = seq_q.kind;
                seq_d.cidx   = seq_q.index;
                seq_d.cval   = seq_d.stage;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{busy: 1'b0, kind: TK_NONE, index: '0, left: '0,
                       stage: '0, cvalid: 1'b0, ckind: TK_NONE,
                       cidx: '0, cval: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cm_valid = seq_q.cvalid;
    assign cm_kind  = seq_q.ckind;
    assign cm_index = seq_q.cidx;
    assign cm_value = seq_q.cval;

endmodule

// File: rtl/wsl_bank.sv
module wsl_bank #(
    parameter int DEPTH    = 16,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 10,
    parameter bit RESET_EN = 1'b1,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_index,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en && int'(wr_index) < DEPTH) begin
            mem_d[wr_index[AW-1:0]] = wr_data;
        end
    end

    generate
        if (RESET_EN) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        mem_q[i] <= '0;
                    end
                end else begin
                    for (int i = 0; i < DEPTH; i++) begin
                        mem_q[i] <= mem_d[i];
                    end
                end
            end
        end else begin : g_norst
            logic unused_rst;
            assign unused_rst = rst_n;
            always_ff @(posedge clk) begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem_q[i] <= mem_d[i];
                end
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (int'(rd_index) < DEPTH) begin
            rd_data = mem_q[rd_index[AW-1:0]];
        end
    end

endmodule

// File: rtl/wsl_loader.sv
module wsl_loader
    import wsl_pkg::*;
#(
    parameter int WORD_W    = 12,
    parameter int COEF_TAPS = 8,
    parameter int COEF_SETS = 256,
    parameter int SEL_REGS  = 16,
    parameter int CFG_REGS  = 2,
    parameter int RND_REGS  = 16,
    parameter int LIM_REGS  = 16,
    localparam int IDX_W    = WORD_W - 2,
    localparam int CNT_W    = $clog2(COEF_TAPS + 1),
    localparam int VAL_W    = COEF_TAPS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [WORD_W-1:0] word_in,
    output logic              commit_valid,
    output logic [2:0]        commit_kind,
    output logic [IDX_W-1:0]  commit_index,
    output logic [VAL_W-1:0]  commit_value,
    input  logic [2:0]        rd_kind,
    input  logic [IDX_W-1:0]  rd_index,
    output logic [VAL_W-1:0]  rd_value
);

    tkind_e           dec_kind;
    logic [IDX_W-1:0] dec_index;
    logic [CNT_W-1:0] dec_words;
    tkind_e           cm_kind;

    wsl_decode #(
        .WORD_W(WORD_W), .COEF_TAPS(COEF_TAPS), .COEF_SETS(COEF_SETS),
        .SEL_REGS(SEL_REGS), .CFG_REGS(CFG_REGS),
        .RND_REGS(RND_REGS), .LIM_REGS(LIM_REGS)
    ) u_decode (
        .addr_word(word_in),
        .dec_kind (dec_kind),
        .dec_index(dec_index),
        .dec_words(dec_words)
    );

    wsl_sequencer #(.WORD_W(WORD_W), .COEF_TAPS(COEF_TAPS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .word_in  (word_in),
        .dec_kind (dec_kind),
        .dec_index(dec_index),
        .dec_words(dec_words),
        .cm_valid (commit_valid),
        .cm_kind  (cm_kind),
        .cm_index (commit_index),
        .cm_value (commit_value)
    );

    assign commit_kind = cm_kind;

    logic [VAL_W-1:0]  coef_rd;
    logic [WORD_W-1:0] sel_rd, cfg_rd;
    logic [WIDE_W-1:0] rnd_rd, lim_rd;

    wsl_bank #(.DEPTH(COEF_SETS), .DATA_W(VAL_W), .IDX_W(IDX_W), .RESET_EN(1'b0)) u_coef (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit_valid && cm_kind == TK_COEF),
        .wr_index(commit_index), .wr_data(commit_value),
        .rd_index(rd_index), .rd_data(coef_rd)
    );

    wsl_bank #(.DEPTH(SEL_REGS), .DATA_W(WORD_W), .IDX_W(IDX_W), .RESET_EN(1'b1)) u_sel (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit_valid && cm_kind == TK_SEL),
        .wr_index(commit_index), .wr_data(commit_value[WORD_W-1:0]),
        .rd_index(rd_index), .rd_data(sel_rd)
    );

    wsl_bank #(.DEPTH(CFG_REGS), .DATA_W(WORD_W), .IDX_W(IDX_W), .RESET_EN(1'b1)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit_valid && cm_kind == TK_CFG),
        .wr_index(commit_index), .wr_data(commit_value[WORD_W-1:0]),
        .rd_index(rd_index), .rd_data(cfg_rd)
    );

    wsl_bank #(.DEPTH(RND_REGS), .DATA_W(WIDE_W), .IDX_W(IDX_W), .RESET_EN(1'b1)) u_rnd (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit_valid && cm_kind == TK_RND),
        .wr_index(commit_index), .wr_data(commit_value[WIDE_W-1:0]),
        .rd_index(rd_index), .rd_data(rnd_rd)
    );

    wsl_bank #(.DEPTH(LIM_REGS), .DATA_W(WIDE_W), .IDX_W(IDX_W), .RESET_EN(1'b1)) u_lim (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit_valid && cm_kind == TK_LIM),
        .wr_index(commit_index), .wr_data(commit_value[WIDE_W-1:0]),
        .rd_index(rd_index), .rd_data(lim_rd)
    );

    always_comb begin
        case (rd_kind)
            3'd1:    rd_value = coef_rd;
            3'd2:    rd_value = VAL_W'(sel_rd);
            3'd3:    rd_value = VAL_W'(cfg_rd);
            3'd4:    rd_value = VAL_W'(rnd_rd);
            3'd5:    rd_value = VAL_W'(lim_rd);
            default: rd_value = '0;
        endcase
    end

endmodule

// File: rtl/wsl_checker.sv
module wsl_checker #(
    parameter int IDX_W     = 10,
    parameter int COEF_SETS = 256,
    parameter int RND_REGS  = 16,
    parameter int LIM_REGS  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             commit_valid,
    input logic [2:0]       commit_kind,
    input logic [IDX_W-1:0] commit_index
);

    // R1 / R8: a commit needs a word captured with load enable low
    assert_commit_needs_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> $past(!load_n));

    // R7: strobe lasts one cycle, since a new address must come in between
    assert_single_cycle_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> !commit_valid);

    // R2: only known kinds are ever committed
    assert_known_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (commit_kind >= 3'd1 && commit_kind <= 3'd5));

    // R2: coefficient index in range
    assert_coef_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && commit_kind == 3'd1) |-> int'(commit_index) < COEF_SETS);

    // R2: round and limit index in range
    assert_wide_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && (commit_kind == 3'd4 || commit_kind == 3'd5))
            |-> (int'(commit_index) < RND_REGS || int'(commit_index) < LIM_REGS));

endmodule

bind wsl_loader wsl_checker #(
    .IDX_W(IDX_W), .COEF_SETS(COEF_SETS), .RND_REGS(RND_REGS), .LIM_REGS(LIM_REGS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .load_n(load_n),
    .commit_valid(commit_valid), .commit_kind(commit_kind),
    .commit_index(commit_index)
);

// File: tb/sim_wsl_loader.sv
module sim_wsl_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_n = 1'b1;
    logic [11:0] word_in = '0;
    logic        commit_valid;
    logic [2:0]  commit_kind;
    logic [9:0]  commit_index;
    logic [95:0] commit_value;
    logic [2:0]  rd_kind = '0;
    logic [9:0]  rd_index = '0;
    logic [95:0] rd_value;

    always #4 clk = ~clk;

    wsl_loader u0 (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .word_in(word_in),
        .commit_valid(commit_valid), .commit_kind(commit_kind),
        .commit_index(commit_index), .commit_value(commit_value),
        .rd_kind(rd_kind), .rd_index(rd_index), .rd_value(rd_value)
    );

    typedef struct {
        logic [2:0]  kind;
        logic [9:0]  idx;
        logic [95:0] val;
        string       req;
    } item_t;

    item_t exp_q[$];
    int tests = 0;
    int fails = 0;

    task automatic check(string req, logic [95:0] act, logic [95:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: every commit must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && commit_valid) begin
            if (exp_q.size() == 0) begin
                tests++;
                fails++;
                $display("FAIL R1/R8/R2 unexpected commit actual=%h/%h/%h expected=none",
                         commit_kind, commit_index, commit_value);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                tests++;
                if ({commit_kind, commit_index, commit_value} !== {e.kind, e.idx, e.val}) begin
                    fails++;
                    $display("FAIL %s actual=%h/%h/%h expected=%h/%h/%h", e.req,
                             commit_kind, commit_index, commit_value, e.kind, e.idx, e.val);
                end
            end
        end
    end

    task automatic push(logic [2:0] k, logic [9:0] i, logic [95:0] v, string req);
        item_t e;
        e.kind = k; e.idx = i; e.val = v; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic put(logic [11:0] w);
        @(negedge clk);
        load_n  = 1'b0;
        word_in = w;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            load_n  = 1'b1;
            word_in = 12'h5A5 ^ 12'(i * 12'h3C7);
        end
    endtask

    task automatic load_coef(logic [7:0] idx, logic [95:0] v, string req);
        push(3'd1, {2'b00, idx}, v, req);
        put({2'b00, 2'b00, idx});
        for (int k = 0; k < 8; k++) put(v[k*12 +: 12]);
    endtask

    task automatic load_bytes(logic kind_lim, logic [3:0] idx, logic [31:0] v,
                              logic [3:0] rsv, string req);
        push(kind_lim ? 3'd5 : 3'd4, {6'b0, idx}, {64'b0, v}, req);
        put({1'b1, kind_lim, 6'b0, idx});
        for (int k = 0; k < 4; k++) put({rsv, v[k*8 +: 8]});
    endtask

    task automatic load_one(logic cfg, logic [3:0] idx, logic [11:0] w, string req);
        push(cfg ? 3'd3 : 3'd2, {6'b0, idx}, {84'b0, w}, req);
        put({2'b01, cfg, 5'b0, idx});
        put(w);
    endtask

    task automatic readback(logic [2:0] k, logic [9:0] i, logic [95:0] exp, string req);
        @(negedge clk);
        rd_kind  = k;
        rd_index = i;
        #1;
        check(req, rd_value, exp);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    localparam logic [95:0] COEF_A = 96'h123_456_789_ABC_DEF_0F1_E2D_3C4;
    localparam logic [95:0] COEF_B = 96'hFFF_000_800_7FF_001_FFE_555_AAA;

    initial begin
        repeat (4) @(negedge clk);
        check("R7 reset commit_valid", {95'b0, commit_valid}, 96'd0);
        readback(3'd2, 10'd2, 96'd0, "R9 reset select");
        readback(3'd5, 10'd7, 96'd0, "R9 reset limit");
        @(negedge clk);
        rst_n = 1'b1;

        // R6 and R7: back-to-back select then configuration
        load_one(1'b0, 4'd2, 12'h00F, "R6 select 2");
        load_one(1'b1, 4'd1, 12'h003, "R6 config 1");
        // R4 with reserved bits set, R5 limit pair
        load_bytes(1'b0, 4'd12, 32'h7683F4A2, 4'hF, "R4 round 12");
        load_bytes(1'b1, 4'd7, 32'h72A43B60, 4'h0, "R5 limit 7");
        // R3 coefficient sets, including the last index
        load_coef(8'd2, COEF_A, "R3 coef 2");
        load_coef(8'd255, COEF_B, "R3 coef 255");
        idle(2);

        // R1: bus activity with load enable high
        idle(6);
        readback(3'd2, 10'd2, 96'h00F, "R1 select 2 unchanged");

        // R8: abort a round transfer after two data words
        put({2'b10, 6'b0, 4'd3});
        put(12'h0AA);
        put(12'h0BB);
        idle(3);
        load_one(1'b0, 4'd5, 12'h5A5, "R8 select 5 after abort");
        idle(2);
        readback(3'd4, 10'd3, 96'd0, "R8 round 3 untouched");

        // R2: out-of-range coefficient address, then a valid select
        put({2'b00, 2'b01, 8'h00});
        load_one(1'b0, 4'd6, 12'h123, "R2 select 6 after bad address");
        // R2: out-of-range round address
        put({2'b10, 6'b000010, 4'd0});
        load_one(1'b1, 4'd0, 12'hABC, "R2 config 0 after bad round");
        idle(3);

        // R9: read back committed storage
        readback(3'd1, 10'd2, COEF_A, "R9 coef 2");
        readback(3'd1, 10'd255, COEF_B, "R9 coef 255");
        readback(3'd4, 10'd12, 96'h7683F4A2, "R9 round 12");
        readback(3'd5, 10'd7, 96'h72A43B60, "R9 limit 7");
        readback(3'd3, 10'd1, 96'h003, "R9 config 1");
        readback(3'd2, 10'd6, 96'h123, "R9 select 6");
        readback(3'd3, 10'd0, 96'hABC, "R9 config 0");

        check("R7 all commits seen", 96'(exp_q.size()), 96'd0);
        finish_run();
    end

endmodule